// File: doc/BRIEF.md
# Scanline Counter Interrupt Unit

This block follows the line number reported by a video generator and raises an interrupt request toward the CPU once a programmed number of visible lines has gone by in the current frame. The video side gives a signed line number and a strobe that marks a new value. The value -1 stands for the pre-render line. The block acts only when the strobed number differs from the last one it recorded. It keeps a flag that is set while the generator is inside the visible part of the frame. The first visible line of each frame starts the count again from zero.

The CPU side has a write port and a read port. One register address holds the 8-bit target line. A second address has two uses. A write to it sets the interrupt enable. A read from it returns the pending event and the in-frame flag. A single-cycle read strobe on that address clears the pending event and releases the interrupt line. The interrupt line is active high and follows the pending event, masked by the enable.

Top module: `scanline_irq_unit`

## Requirements
- R1: After reset, the interrupt line is low, and a read of address 0x5204 returns 0x00.
- R2: A line number is acted on only when the line strobe is high and the number differs from the last recorded one. That number then becomes the recorded one. A repeated number, or a number presented without the strobe, changes nothing.
- R3: A new line number below 0, or of 239 or above, clears the in-frame flag and does not advance the counter.
- R4: A new line number in the range 0 to 238, arriving while the in-frame flag is clear, sets the flag. It also zeroes the line counter, clears the pending event and drops the interrupt line.
- R5: A new line number lower than the recorded one clears the in-frame flag before that line is evaluated. A visible line that goes backwards therefore starts a fresh frame with the count at zero.
- R6: A new visible line while in frame increments the 8-bit counter. If the incremented value equals the target, the pending event is set, and the interrupt line rises on the next clock if the enable is set.
- R7: A write to address 0x5203 loads all 8 data bits as the target line.
- R8: A write to address 0x5204 sets the enable from data bit 7. Clearing the enable drops the interrupt line. Setting it while an event is pending raises the line on the next clock. The pending event survives both.
- R9: The read data at address 0x5204 carries the pending event in bit 7 and the in-frame flag in bit 6, with bits 5 to 0 at zero. Any other read address returns 0x00.
- R10: A read strobe at address 0x5204 returns the status as it stood before the access. The pending event is then clear and the interrupt line low from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lineValid | input | 1 | Strobe marking a line number to evaluate |
| lineNum | input | 9 | Signed line number; -1 is pre-render |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 16 | Register write address |
| wrData | input | 8 | Register write data |
| rdEn | input | 1 | Single-cycle read strobe (clears the pending event at the status address) |
| rdAddr | input | 16 | Register read address |
| rdData | output | 8 | Read data for rdAddr, combinational |
| irqOut | output | 1 | Active-high interrupt request |

## Verification
The bench sweeps every 8-bit target over a full frame and checks the interrupt line after each line. This catches an off-by-one compare that fires a line early or late. It also catches a design that never fires for targets 1 and 238, or that fires for target 0 or for targets above 238. Repeated and unstrobed line numbers are presented mid-frame, because a design that counts them would reach the target early. A backwards jump inside the visible range is checked for a restart at zero, where a design that only tests range would keep counting. A frame start while an event is pending is checked to drop the line, where a faulty design would leave a stale interrupt. The enable is toggled while an event is pending, and the status is read, so that a lost event, a line that stays high after a read, or a cleared value returned by the read all show up.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  // Strobes from the control decoder to the datapath, one cycle each.
  typedef struct packed {
    logic recordLine;   // latch the new line number
    logic leaveFrame;   // line outside the visible range
    logic startFrame;   // first visible line of a frame
    logic countLine;    // further visible line inside a frame
    logic loadTarget;   // write to the target register
    logic loadEnable;   // write to the control register
    logic enableValue;  // enable bit carried with loadEnable
    logic readClear;    // status read side effect
    logic statusSel;    // read address selects the status register
  } sirq_strobe_t;

endpackage

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
  import sirq_pkg::*;
#(
  parameter int LINE_W        = 9,
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int VISIBLE_LINES = 239,
  parameter logic [ADDR_W-1:0] TARGET_ADDR  = 16'h5203,
  parameter logic [ADDR_W-1:0] CONTROL_ADDR = 16'h5204
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lineValid,
  input  logic signed [LINE_W-1:0] lineNum,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     rdEn,
  input  logic [ADDR_W-1:0]        rdAddr,
  input  logic signed [LINE_W-1:0] prevLine,
  input  logic                     inFrame,
  output sirq_strobe_t             strobe
);

  localparam logic signed [LINE_W-1:0] LINE_LIMIT = LINE_W'(VISIBLE_LINES);

  logic lineChange;
  logic wentBack;
  logic outOfRange;
  logic stillIn;

  always_comb begin
    lineChange = lineValid && (lineNum != prevLine);
    wentBack   = lineNum < prevLine;
    outOfRange = lineNum[LINE_W-1] || (lineNum >= LINE_LIMIT);
    stillIn    = inFrame && !wentBack;
  end

  always_comb begin
    strobe             = '0;
    strobe.recordLine  = lineChange;
    strobe.leaveFrame  = lineChange && outOfRange;
    strobe.startFrame  = lineChange && !outOfRange && !stillIn;
    strobe.countLine   = lineChange && !outOfRange && stillIn;
    strobe.loadTarget  = wrEn && (wrAddr == TARGET_ADDR);
    strobe.loadEnable  = wrEn && (wrAddr == CONTROL_ADDR);
    strobe.enableValue = wrData[DATA_W-1];
    strobe.statusSel   = (rdAddr == CONTROL_ADDR);
    strobe.readClear   = rdEn && (rdAddr == CONTROL_ADDR);
  end

  // R3/R4/R6: at most one line event per cycle
  p_one_line_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.leaveFrame, strobe.startFrame, strobe.countLine}));

  // R2: an unchanged or unstrobed line number raises no event
  p_idle_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lineValid || lineNum == prevLine) |->
      !(strobe.recordLine || strobe.startFrame || strobe.countLine || strobe.leaveFrame));

endmodule

// File: rtl/sirq_datapath.sv
module sirq_datapath
  import sirq_pkg::*;
#(
  parameter int LINE_W = 9,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  sirq_strobe_t             strobe,
  input  logic signed [LINE_W-1:0] lineNum,
  input  logic [DATA_W-1:0]        wrData,
  output logic signed [LINE_W-1:0] prevLine,
  output logic                     inFrame,
  output logic [DATA_W-1:0]        rdData,
  output logic                     irqOut
);

  localparam int PEND_BIT  = DATA_W - 1;
  localparam int FRAME_BIT = DATA_W - 2;

  logic signed [LINE_W-1:0] prevLineQ;
  logic                     inFrameQ;
  logic [CNT_W-1:0]         cntQ;
  logic [CNT_W-1:0]         targetQ;
  logic                     enQ;
  logic                     pendQ;
  logic                     irqQ;

  logic [CNT_W-1:0] cntInc;
  logic             hit;
  logic             enN;
  logic             pendN;
  logic             irqN;

  always_comb begin
    cntInc = cntQ + CNT_W'(1);
    hit    = (cntInc == targetQ);
  end

  // Register side effects first, then line events, which take precedence.
  always_comb begin
    enN   = enQ;
    pendN = pendQ;
    irqN  = irqQ;
    if (strobe.loadEnable) begin
      enN = strobe.enableValue;
      if (!strobe.enableValue) irqN = 1'b0;
      else if (pendQ)          irqN = 1'b1;
    end
    if (strobe.readClear) begin
      pendN = 1'b0;
      irqN  = 1'b0;
    end
    if (strobe.startFrame) begin
      pendN = 1'b0;
      irqN  = 1'b0;
    end else if (strobe.countLine && hit) begin
      pendN = 1'b1;
      if (enN) irqN = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevLineQ <= -LINE_W'(1);
      inFrameQ  <= 1'b0;
      cntQ      <= '0;
      targetQ   <= '0;
      enQ       <= 1'b0;
      pendQ     <= 1'b0;
      irqQ      <= 1'b0;
    end else begin
      if (strobe.recordLine) prevLineQ <= lineNum;
      if (strobe.loadTarget) targetQ <= wrData[CNT_W-1:0];
      if (strobe.leaveFrame)      inFrameQ <= 1'b0;
      else if (strobe.startFrame) inFrameQ <= 1'b1;
      if (strobe.startFrame)     cntQ <= '0;
      else if (strobe.countLine) cntQ <= cntInc;
      enQ   <= enN;
      pendQ <= pendN;
      irqQ  <= irqN;
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.statusSel) begin
      rdData[PEND_BIT]  = pendQ;
      rdData[FRAME_BIT] = inFrameQ;
    end
  end

  assign prevLine = prevLineQ;
  assign inFrame  = inFrameQ;
  assign irqOut   = irqQ;

  // R8: the interrupt line always equals pending masked by enable
  p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irqQ == (pendQ && enQ));

  // R2: an evaluated line number is recorded
  p_line_recorded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.recordLine |=> prevLineQ == $past(lineNum));

  // R4: a frame start zeroes the count and the event
  p_frame_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.startFrame |=> (inFrameQ && cntQ == '0 && !pendQ && !irqQ));

  // R3: out-of-range lines leave the frame without counting
  p_leave_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.leaveFrame |=> (!inFrameQ && $stable(cntQ)));

  // R6: an in-frame visible line steps the counter by one
  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.countLine |=> cntQ == $past(cntQ) + CNT_W'(1));

  // R10: a status read without a competing hit leaves nothing pending
  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.readClear && !strobe.countLine) |=> (!pendQ && !irqQ));

endmodule

// File: rtl/scanline_irq_unit.sv
module scanline_irq_unit
  import sirq_pkg::*;
#(
  parameter int LINE_W        = 9,
  parameter int CNT_W         = 8,
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int VISIBLE_LINES = 239,
  parameter logic [ADDR_W-1:0] TARGET_ADDR  = 16'h5203,
  parameter logic [ADDR_W-1:0] CONTROL_ADDR = 16'h5204
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lineValid,
  input  logic signed [LINE_W-1:0] lineNum,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     rdEn,
  input  logic [ADDR_W-1:0]        rdAddr,
  output logic [DATA_W-1:0]        rdData,
  output logic                     irqOut
);

  sirq_strobe_t             strobe;
  logic signed [LINE_W-1:0] prevLine;
  logic                     inFrame;

  sirq_ctrl #(
    .LINE_W(LINE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .VISIBLE_LINES(VISIBLE_LINES),
    .TARGET_ADDR(TARGET_ADDR), .CONTROL_ADDR(CONTROL_ADDR)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .lineValid(lineValid), .lineNum(lineNum),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr),
    .prevLine(prevLine), .inFrame(inFrame),
    .strobe(strobe)
  );

  sirq_datapath #(
    .LINE_W(LINE_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) u_datapath (
    .clk(clk), .rst_n(rst_n),
    .strobe(strobe), .lineNum(lineNum), .wrData(wrData),
    .prevLine(prevLine), .inFrame(inFrame),
    .rdData(rdData), .irqOut(irqOut)
  );

endmodule

// File: tb/scanline_irq_unit_bench.sv
module scanline_irq_unit_bench;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lineValid = 1'b0;
  logic signed [8:0] lineNum = '0;
  logic              wrEn = 1'b0;
  logic [15:0]       wrAddr = '0;
  logic [7:0]        wrData = '0;
  logic              rdEn = 1'b0;
  logic [15:0]       rdAddr = '0;
  logic [7:0]        rdData;
  logic              irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  scanline_irq_unit u_scanline_irq_unit (
    .clk(clk), .rst_n(rst_n),
    .lineValid(lineValid), .lineNum(lineNum),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic stepLine(input int n);
    lineNum = 9'(n);
    lineValid = 1'b1;
    @(negedge clk);
    lineValid = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wrAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdStatus(output logic [7:0] v);
    rdAddr = 16'h5204; rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic peek(input logic [15:0] a, output logic [7:0] v);
    rdAddr = a;
    #1 v = rdData;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      finishRun();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    peek(16'h5204, v);
    chk("R1 status after reset", v, 8'h00);
    chk("R1 irq after reset", irqOut, 0);

    // R2: repeated / unstrobed line numbers are ignored
    wr(16'h5203, 8'd2);
    wr(16'h5204, 8'h80);
    stepLine(0);
    stepLine(1);
    stepLine(1); stepLine(1); stepLine(1);
    lineNum = 9'sd2; lineValid = 1'b0;
    @(negedge clk);
    peek(16'h5204, v);
    chk("R2 no event from repeats", v, 8'h40);
    chk("R2 irq low after repeats", irqOut, 0);
    stepLine(2);
    chk("R2 irq rises on real line 2", irqOut, 1);

    // R10: read returns pre-clear status then clears
    rdStatus(v);
    chk("R10 read value before clear", v, 8'hC0);
    chk("R10 irq dropped after read", irqOut, 0);
    peek(16'h5204, v);
    chk("R10 pending cleared", v, 8'h40);

    // R9: other address reads zero
    peek(16'h5203, v);
    chk("R9 other address reads zero", v, 8'h00);

    // R5: backwards visible line restarts the count
    for (int l = 3; l <= 10; l++) stepLine(l);
    wr(16'h5203, 8'd3);
    stepLine(2);
    stepLine(3);
    stepLine(4);
    chk("R5 no hit before restarted count reaches 3", irqOut, 0);
    stepLine(5);
    chk("R5 hit after restart", irqOut, 1);

    // R4: frame start clears a stale pending event
    stepLine(239);
    peek(16'h5204, v);
    chk("R3 line 239 leaves frame, pending kept", v, 8'h80);
    stepLine(0);
    peek(16'h5204, v);
    chk("R4 frame start clears pending", v, 8'h40);
    chk("R4 frame start drops irq", irqOut, 0);

    // R3: pre-render line leaves frame
    stepLine(-1);
    peek(16'h5204, v);
    chk("R3 negative line leaves frame", v, 8'h00);

    // R8: enable toggling around a pending event
    wr(16'h5203, 8'd1);
    stepLine(0);
    stepLine(1);
    chk("R6 target 1 hit", irqOut, 1);
    wr(16'h5204, 8'h00);
    chk("R8 disable drops irq", irqOut, 0);
    peek(16'h5204, v);
    chk("R8 pending survives disable", v, 8'hC0);
    wr(16'h5204, 8'h7F);
    chk("R8 bit7 clear keeps disabled", irqOut, 0);
    wr(16'h5204, 8'h80);
    chk("R8 enable while pending raises irq", irqOut, 1);
    rdStatus(v);
    wr(16'h5204, 8'h00);
    stepLine(-1);

    // R6/R7/R8/R10 sweep of every target over a full frame
    for (int t = 0; t < 256; t++) begin
      bit en;
      bit pendExp;
      en = t[0];
      wr(16'h5203, 8'(t));
      wr(16'h5204, en ? 8'h80 : 8'h00);
      stepLine(-1);
      pendExp = 1'b0;
      for (int l = 0; l <= 238; l++) begin
        stepLine(l);
        if (l >= 1 && l == t) pendExp = 1'b1;
        chk($sformatf("R6 t=%0d line=%0d irq", t, l), irqOut, int'(en && pendExp));
      end
      peek(16'h5204, v);
      chk($sformatf("R7 t=%0d status end of frame", t), v, pendExp ? 8'hC0 : 8'h40);
      stepLine(239);
      peek(16'h5204, v);
      chk($sformatf("R3 t=%0d after line 239", t), v, pendExp ? 8'h80 : 8'h00);
      if (!en) begin
        wr(16'h5204, 8'h80);
        chk($sformatf("R8 t=%0d late enable", t), irqOut, int'(pendExp));
      end
      rdStatus(v);
      chk($sformatf("R10 t=%0d read value", t), v, pendExp ? 8'h80 : 8'h00);
      chk($sformatf("R10 t=%0d irq after read", t), irqOut, 0);
      wr(16'h5204, 8'h00);
    end

    done = 1'b1;
    finishRun();
  end

endmodule